// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an intermediate-frequency logic signal. It counts the signal's rising edges during a gate window of known length, and the window is timed from a 75 kHz time-base strobe. Software first writes a 4-bit setup word that holds a mode field and a gate-time code. It then issues a start command. When the window closes, a completion flag rises and the edge count can be read and scaled to a frequency.

The measured input is assumed to be already squared to logic levels. It is resynchronised into the system clock domain, and a rising edge is detected after the synchroniser. The system clock must therefore run at least twice as fast as the highest input frequency, which is 12 MHz. A separate disable input stops edge counting while the surrounding chip is halted, in backup, or has its synthesiser stopped.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, `count` is 0, `done` is 0 and `busy` is 0. The setup register resets to mode 00 and gate code 00.
- R2: The setup word `cfg_data[1:0]` is the gate code. Codes 00, 01, 10 and 11 give windows of 75, 300, 600 and 2400 time-base strobes (1, 4, 8 and 32 ms at 75 kHz). `done` rises in the cycle after the last strobe of the window, where the strobes are counted from the clock edge after the edge that accepted the start.
- R3: A start is accepted only while the mode field `cfg_data[3:2]` held in the setup register is 00. A start in any other mode leaves `busy`, `done` and `count` unchanged.
- R4: An accepted start clears `count` and `done` and raises `busy` on the next clock edge. A start during an open window begins a fresh measurement.
- R5: While `busy` is high, `count` advances by one for each rising edge of `sig_in`. Each level of `sig_in` must last at least two clock cycles. `count` reflects an edge three clock edges after it occurs.
- R6: `count` saturates at its all-ones value instead of wrapping.
- R7: A rising edge seen while `gate_off` is high is not counted.
- R8: The gate code is captured when a start is accepted. A setup write during the window does not change that window's length.
- R9: Once `done` is high, `count` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the setup word |
| cfg_data | input | 4 | Setup word: [3:2] mode, [1:0] gate code |
| start | input | 1 | Start command, one cycle |
| base_tick | input | 1 | 75 kHz time-base strobe, one cycle wide |
| gate_off | input | 1 | High while the input must be ignored (low-power modes) |
| sig_in | input | 1 | Squared signal to be measured |
| count | output | CNT_W | Edge count of the current or last window |
| done | output | 1 | Window closed, count valid |
| busy | output | 1 | Window open |

## Verification
The assertions assume that `base_tick` is a single-cycle strobe and that `sig_in` changes no faster than every two clock cycles. Without that, the edge detector could miss an edge, and the rule that the count steps by at most one per cycle would be the only guard left. The stimulus drives the strobe exactly every fourth cycle. It toggles the signal with even periods of four cycles or more. Every burst of edges ends well before the window closes, so the expected count never depends on the three-cycle latency of the synchroniser.

// File: rtl/if_freq_counter_pkg.sv
package if_freq_counter_pkg;
  localparam logic [1:0] MODE_FREQ = 2'b00;

  // window multiplier per gate code, in units of the 1 ms base window
  function automatic int unsigned gate_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 32;
    endcase
  endfunction

  function automatic int unsigned gate_ticks(input logic [1:0] code, input int unsigned per_ms);
    return per_ms * gate_mult(code);
  endfunction
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
  import if_freq_counter_pkg::*;
#(
  parameter int TICKS_PER_MS = 75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [1:0] code,
  input  logic       tick,
  output logic       active,
  output logic       close
);
  localparam int TW = $clog2(TICKS_PER_MS * 32 + 1);

  logic [TW-1:0] tcnt_q;
  logic [1:0]    code_q;
  logic [TW-1:0] last_idx;

  assign last_idx = TW'(gate_ticks(code_q, TICKS_PER_MS) - 1);
  assign close    = active & tick & ~launch & (tcnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      tcnt_q <= '0;
      code_q <= 2'b00;
    end else if (launch) begin
      active <= 1'b1;
      tcnt_q <= '0;
      code_q <= code;
    end else if (close) begin
      active <= 1'b0;
    end else if (active && tick) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   value <= '0;
    else if (clr)                 value <= '0;
    else if (inc && value != TOP) value <= value + 1'b1;
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter
  import if_freq_counter_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int TICKS_PER_MS = 75,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_data,
  input  logic             start,
  input  logic             base_tick,
  input  logic             gate_off,
  input  logic             sig_in,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             busy
);
  logic [1:0] mode_q, code_q;
  logic       launch, win_close, edge_seen, count_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'b00;
      code_q <= 2'b00;
    end else if (cfg_we) begin
      mode_q <= cfg_data[3:2];
      code_q <= cfg_data[1:0];
    end

  assign launch = start & (mode_q == MODE_FREQ);

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(edge_seen)
  );

  ifc_gate_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .code(code_q),
    .tick(base_tick), .active(busy), .close(win_close)
  );

  assign count_en = busy & edge_seen & ~gate_off;

  ifc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(launch), .inc(count_en), .value(count)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         done <= 1'b0;
    else if (launch)    done <= 1'b0;
    else if (win_close) done <= 1'b1;
endmodule

// File: rtl/if_freq_counter_chk.sv
module if_freq_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic             win_close,
  input logic             gate_off,
  input logic [CNT_W-1:0] count,
  input logic             done,
  input logic             busy
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (count == '0) && !done && busy);

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !launch) |=> count == TOP);

  // R7
  gated_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off && !launch) |=> $stable(count));

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(win_close));

  // R9
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> $stable(count));

  // R4
  always @(posedge clk)
    if (rst_n) begin
      done_busy_excl_chk: assert (!(done && busy));
    end
endmodule

bind if_freq_counter if_freq_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .win_close(win_close),
  .gate_off(gate_off), .count(count), .done(done), .busy(busy)
);

// File: tb/if_freq_counter_test.sv
module if_freq_counter_test;
  localparam int PER_MS = 75;
  localparam int NW     = 5;

  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0, base_tick = 0, gate_off = 0, sig_in = 0;
  logic [3:0]  cfg_data = 4'h0;
  logic [19:0] count;
  logic        done, busy;
  logic [NW-1:0] count_n;
  logic        done_n, busy_n;

  int total = 0, bad = 0;
  int tick_seen = 0;
  logic [1:0] phase = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  if_freq_counter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .start(start),
    .base_tick(base_tick), .gate_off(gate_off), .sig_in(sig_in),
    .count(count), .done(done), .busy(busy)
  );

  if_freq_counter #(.CNT_W(NW)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .start(start),
    .base_tick(base_tick), .gate_off(gate_off), .sig_in(sig_in),
    .count(count_n), .done(done_n), .busy(busy_n)
  );

  always @(negedge clk) begin
    phase     <= phase + 2'd1;
    base_tick <= (phase == 2'd3);
  end

  always @(posedge clk)
    if (start) tick_seen <= 0;
    else if (base_tick) tick_seen <= tick_seen + 1;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] mode, input logic [1:0] code);
    @(negedge clk); cfg_we = 1; cfg_data = {mode, code};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send_edges(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig_in = 1;
      repeat (p/2 - 1) @(negedge clk);
      @(negedge clk); sig_in = 0;
      repeat (p/2 - 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  function automatic int ticks_for(input int code);
    int m;
    m = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 32;
    return PER_MS * m;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int periods[3] = '{4, 6, 10};
    longint held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);

    // R2 / R5 sweep over gate codes and input periods
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (ticks_for(c) * 4 - 40) / periods[k];
        if (n > 150) n = 150;
        write_cfg(2'b00, 2'(c));
        pulse_start();
        // R4 start raised busy, cleared done
        check("R4 busy after start", busy, 1);
        check("R4 done cleared", done, 0);
        send_edges(n, periods[k]);
        wait_done();
        check("R2 window strobes", tick_seen, ticks_for(c));
        check("R5 edge count", count, n);
        check("R2 busy low at done", busy, 0);
      end
    end

    // R9 count holds after completion
    held = count;
    repeat (50) @(negedge clk);
    check("R9 count held", count, held);

    // R3 start ignored in another mode
    write_cfg(2'b01, 2'b00);
    pulse_start();
    repeat (3) @(negedge clk);
    check("R3 busy", busy, 0);
    check("R3 done", done, 1);
    check("R3 count", count, held);

    // R4 restart during a window
    write_cfg(2'b00, 2'b00);
    pulse_start();
    send_edges(10, 4);
    check("R4 mid count", count, 10);
    pulse_start();
    check("R4 restart clears", count, 0);
    send_edges(7, 4);
    wait_done();
    check("R4 restart count", count, 7);
    check("R4 restart window", tick_seen, 75);

    // R7 gated input
    pulse_start();
    send_edges(5, 10);
    @(negedge clk); gate_off = 1;
    send_edges(8, 10);
    @(negedge clk); gate_off = 0;
    send_edges(3, 10);
    wait_done();
    check("R7 gated count", count, 8);

    // R8 gate code captured at start
    pulse_start();
    repeat (20) @(negedge clk);
    write_cfg(2'b00, 2'b11);
    wait_done();
    check("R8 window kept", tick_seen, 75);
    write_cfg(2'b00, 2'b00);

    // R6 saturation on narrow instance; R5 zero edges
    pulse_start();
    send_edges(40, 4);
    wait_done();
    check("R6 wide count", count, 40);
    check("R6 narrow saturated", count_n, 31);
    pulse_start();
    wait_done();
    check("R5 no edges", count, 0);
    check("R6 narrow cleared", count_n, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule